// File: doc/BRIEF.md
# Nested Three-Level Vectored Interrupt Arbiter

This block chooses which of nine interrupt sources gets to interrupt the CPU. Each source has a one-bit level select. The first two sources choose between the top level and the bottom level. The other seven choose between the middle level and the bottom level. The three levels, from highest to lowest, are X, H and L.

The block tracks which levels are in service with one flag per level. It raises a pending signal only for a request whose level is strictly above every level in service. When several requests qualify, the highest level wins. Among requests at the same level, the source with the lowest vector address wins. Pending and vector are combinational.

The CPU samples pending and vector when it asserts the acknowledge strobe. The acknowledge marks the granted level as in service. A return strobe ends the innermost handler. Clearing the request stays with the peripheral that raised it.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset no level is in service, so with no request active `irq_pend_o` is 0 and `vec_addr_o` is 0.
- R2: Level mapping. For sources 0 and 1, a level select of 1 gives level X and 0 gives level L. For sources 2 to 8, a level select of 1 gives level H and 0 gives level L. The order is X > H > L.
- R3: The vector address of source n (n = 0..8) is, in order, 0x03, 0x0B, 0x13, 0x1B, 0x23, 0x33, 0x3B, 0x43, 0x4B.
- R4: Among qualifying requests, one at a higher level always wins over one at a lower level, whatever their source numbers.
- R5: Among qualifying requests at the same level, the lowest source number (lowest address) wins.
- R6: A request whose level is equal to or below the highest level in service does not qualify. If no request qualifies, `irq_pend_o` is 0.
- R7: A request whose level is strictly above the highest level in service qualifies, so handlers nest.
- R8: When `ack_i` is 1 while `irq_pend_o` is 1, the granted level is marked in service at the next clock edge.
- R9: When `reti_i` is 1 at a clock edge, only the highest in-service flag is cleared. With nothing in service, the strobe has no effect.
- R10: When `ack_i` is 1 while `irq_pend_o` is 0, the in-service state does not change.
- R11: When `ack_i` (with `irq_pend_o` at 1) and `reti_i` are both 1 in the same cycle, the highest in-service flag is cleared and the granted level is set.
- R12: While `irq_pend_o` is 0, `vec_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 9 | Request line per source; bit n is source n |
| lvl_sel_i | input | 9 | Level select per source (see R2) |
| ack_i | input | 1 | CPU acknowledge strobe |
| reti_i | input | 1 | CPU return-from-interrupt strobe |
| irq_pend_o | output | 1 | A qualifying request exists |
| vec_addr_o | output | 8 | Vector address of the winning source, 0 when none |

## Verification
Sources are first driven one at a time, which gives the address of each source and the level mapping apart. Pairs and groups that mix levels show whether level beats source number, and groups at one level show the lowest-index tie-break. Nesting runs raise H, then X, then return in stages. After each step, requests at the same level, a lower level and a higher level tell refusal apart from nesting. A long run of pseudo-random requests, level selects and strobes, including acknowledge with nothing pending and acknowledge together with return, is compared every cycle against a queue-based model.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NUM_LVL = 3;

    typedef enum logic [1:0] {
        LVL_L = 2'd0,
        LVL_H = 2'd1,
        LVL_X = 2'd2
    } irq_lvl_e;

    typedef struct packed {
        logic [NUM_LVL-1:0] in_svc;
    } svc_state_t;

    // Vector slots step by 8, with one unused slot skipped after source 4.
    function automatic logic [7:0] slot_addr(input int idx);
        int a;
        a = 3 + 8 * idx + ((idx >= 5) ? 8 : 0);
        return a[7:0];
    endfunction

endpackage

// File: rtl/irq_level_map.sv
module irq_level_map #(
    parameter int NUM_VEC = 9,
    parameter int NUM_TOP = 2
) (
    input  logic [NUM_VEC-1:0]      sel_i,
    output logic [NUM_VEC-1:0][1:0] lvl_o
);
    import irq_nest_pkg::*;

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_src
        if (i < NUM_TOP) begin : g_top
            assign lvl_o[i] = sel_i[i] ? LVL_X : LVL_L;
        end else begin : g_mid
            assign lvl_o[i] = sel_i[i] ? LVL_H : LVL_L;
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_VEC = 9,
    parameter int ADDR_W  = 8
) (
    input  logic [NUM_VEC-1:0]      req_i,
    input  logic [NUM_VEC-1:0][1:0] lvl_i,
    input  logic [2:0]              in_svc_i,
    output logic                    pend_o,
    output logic [1:0]              grant_lvl_o,
    output logic [ADDR_W-1:0]       vec_o
);
    import irq_nest_pkg::*;

    logic [NUM_LVL-1:0] allowed;
    int                 best_idx;

    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            allowed[l] = ~|(in_svc_i >> l);
        end
        pend_o      = 1'b0;
        grant_lvl_o = 2'd0;
        best_idx    = 0;
        // Ascending levels, descending sources: the last hit is the highest
        // level and, within it, the lowest source.
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int i = NUM_VEC - 1; i >= 0; i--) begin
                if (req_i[i] && (lvl_i[i] == 2'(l)) && allowed[l]) begin
                    pend_o      = 1'b1;
                    grant_lvl_o = 2'(l);
                    best_idx    = i;
                end
            end
        end
        vec_o = pend_o ? ADDR_W'(slot_addr(best_idx)) : '0;
    end

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_i,
    input  logic       reti_i,
    input  logic       pend_i,
    input  logic [1:0] grant_lvl_i,
    output logic [2:0] in_svc_o
);
    import irq_nest_pkg::*;

    svc_state_t st_d, st_q;
    logic       found;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        if (reti_i) begin
            for (int l = NUM_LVL - 1; l >= 0; l--) begin
                if (!found && st_q.in_svc[l]) begin
                    st_d.in_svc[l] = 1'b0;
                    found          = 1'b1;
                end
            end
        end
        if (ack_i && pend_i) begin
            st_d.in_svc[grant_lvl_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_svc_o = st_q.in_svc;

endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter #(
    parameter int NUM_VEC = 9,
    parameter int NUM_TOP = 2,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req_i,
    input  logic [NUM_VEC-1:0] lvl_sel_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_pend_o,
    output logic [ADDR_W-1:0]  vec_addr_o
);

    logic [NUM_VEC-1:0][1:0] src_lvl;
    logic [2:0]              in_svc_q;
    logic [1:0]              grant_lvl;

    irq_level_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) u_map (
        .sel_i (lvl_sel_i),
        .lvl_o (src_lvl)
    );

    irq_pick #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_pick (
        .req_i       (req_i),
        .lvl_i       (src_lvl),
        .in_svc_i    (in_svc_q),
        .pend_o      (irq_pend_o),
        .grant_lvl_o (grant_lvl),
        .vec_o       (vec_addr_o)
    );

    irq_svc_stack u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .reti_i      (reti_i),
        .pend_i      (irq_pend_o),
        .grant_lvl_i (grant_lvl),
        .in_svc_o    (in_svc_q)
    );

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NUM_VEC = 9,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_VEC-1:0] req,
    input logic               ack,
    input logic               reti,
    input logic               pend,
    input logic [ADDR_W-1:0]  vec,
    input logic [2:0]         in_svc
);

    // R12: no pending request means a zero vector
    a_r12_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |-> (vec == '0));

    // R6: pending needs at least one request line
    a_r6_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (req != '0));

    // R3: a pending vector is one of the legal slots
    a_r3_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> ((vec[2:0] == 3'd3) && (vec != 8'h2B) && (vec <= 8'h4B)));

    // R8: an accepted acknowledge adds exactly one in-service flag
    a_r8_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend && !reti) |=> ($countones(in_svc) == $past($countones(in_svc)) + 1));

    // R9: a return with something in service removes exactly one flag
    a_r9_reti_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && (in_svc != 3'b000)) |=> ($countones(in_svc) == $past($countones(in_svc)) - 1));

    // R10: an acknowledge with nothing pending leaves the state alone
    a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend && !reti) |=> $stable(in_svc));

endmodule

bind irq_nest_arbiter irq_nest_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_i),
    .ack    (ack_i),
    .reti   (reti_i),
    .pend   (irq_pend_o),
    .vec    (vec_addr_o),
    .in_svc (in_svc_q)
);

// File: tb/irq_nest_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_nest_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] req = '0;
    logic [8:0] sel = '0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       pend;
    logic [7:0] vec;

    int n_chk = 0;
    int n_err = 0;
    int svc_q[$];
    logic       exp_pend;
    logic [7:0] exp_vec;
    int         exp_lvl;
    logic [7:0] last_vec;
    logic       last_pend;

    always #2.5 clk = ~clk;

    irq_nest_arbiter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .lvl_sel_i  (sel),
        .ack_i      (ack),
        .reti_i     (reti),
        .irq_pend_o (pend),
        .vec_addr_o (vec)
    );

    function automatic int src_level(int i, logic s);
        if (!s) return 0;
        return (i < 2) ? 2 : 1;
    endfunction

    function automatic logic [7:0] addr_of(int i);
        case (i)
            0: return 8'h03; 1: return 8'h0B; 2: return 8'h13;
            3: return 8'h1B; 4: return 8'h23; 5: return 8'h33;
            6: return 8'h3B; 7: return 8'h43; default: return 8'h4B;
        endcase
    endfunction

    task automatic model_expect();
        int cur;
        int best;
        cur = (svc_q.size() > 0) ? svc_q[$] : -1;
        best = -1;
        exp_lvl = -1;
        for (int i = 0; i < 9; i++) begin
            int l;
            l = src_level(i, sel[i]);
            if (req[i] && l > cur && l > exp_lvl) begin
                best = i;
                exp_lvl = l;
            end
        end
        exp_pend = (best >= 0);
        exp_vec  = exp_pend ? addr_of(best) : 8'h00;
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [8:0] r, input logic [8:0] s,
                        input logic a, input logic t, input string tag);
        @(negedge clk);
        req = r; sel = s; ack = a; reti = t;
        #1;
        model_expect();
        last_pend = pend;
        last_vec  = vec;
        check_eq({tag, " pend"}, pend, exp_pend);
        check_eq({tag, " vec"}, vec, exp_vec);
        @(posedge clk);
        if (t && svc_q.size() > 0) void'(svc_q.pop_back());
        if (a && exp_pend) svc_q.push_back(exp_lvl);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        step('0, '0, 0, 0, "R1 reset idle");
        check_eq("R1 pend literal", last_pend, 0);
        check_eq("R12 vec literal", last_vec, 0);

        // R3: every source alone, both select values
        for (int i = 0; i < 9; i++) begin
            step(9'(1 << i), '1, 0, 0, "R3 single high");
            check_eq("R3 address literal", last_vec, addr_of(i));
            step(9'(1 << i), '0, 0, 0, "R3 single low");
        end

        // R2: source 0 at L loses to source 2 at H; at X it wins
        step(9'b000000101, 9'b000000100, 0, 0, "R2 L vs H");
        check_eq("R2 H beats L literal", last_vec, 8'h13);
        step(9'b000000101, 9'b000000101, 0, 0, "R2 X vs H");
        check_eq("R2 X literal", last_vec, 8'h03);

        // R4: higher level wins over lower index
        step(9'b100000011, 9'b100000000, 0, 0, "R4 level over index");
        check_eq("R4 literal", last_vec, 8'h4B);
        // R5: tie goes to lowest index
        step(9'b110100000, 9'b110100000, 0, 0, "R5 tie H");
        check_eq("R5 literal", last_vec, 8'h33);
        step(9'b001100100, 9'b000000000, 0, 0, "R5 tie L");

        // R8: acknowledge an H source
        step(9'b000001000, 9'b111111111, 1, 0, "R8 ack H");
        // R6: same and lower level held off
        step(9'b000000100, 9'b111111111, 0, 0, "R6 same level held");
        check_eq("R6 literal", last_pend, 0);
        step(9'b000000100, 9'b000000000, 0, 0, "R6 lower held");
        // R7: X nests over H
        step(9'b000000110, 9'b111111111, 0, 0, "R7 X nests");
        check_eq("R7 literal", last_vec, 8'h0B);
        step(9'b000000010, 9'b111111111, 1, 0, "R7 ack X");
        step(9'b000000011, 9'b111111111, 0, 0, "R6 X held under X");
        // R9: return clears X only, H still held
        step('0, '1, 0, 1, "R9 reti X");
        step(9'b000010000, 9'b111111111, 0, 0, "R9 H still held");
        check_eq("R9 literal", last_pend, 0);
        step(9'b000000001, 9'b111111111, 0, 0, "R9 X allowed again");
        step('0, '1, 0, 1, "R9 reti H");
        step(9'b000010000, 9'b000000000, 0, 0, "R9 L allowed");
        check_eq("R9 L literal", last_vec, 8'h23);
        step('0, '0, 0, 1, "R9 reti empty");
        step(9'b000010000, 9'b000000000, 0, 0, "R9 empty stays");

        // R10: ack with nothing pending
        step('0, '0, 1, 0, "R10 idle ack");
        step(9'b000000100, 9'b000000000, 0, 0, "R10 L still allowed");
        check_eq("R10 literal", last_pend, 1);

        // R11: H in service, X acked together with return
        step(9'b000000100, 9'b111111111, 1, 0, "R11 ack H");
        step(9'b000000001, 9'b111111111, 1, 1, "R11 ack+reti");
        step(9'b000000100, 9'b111111111, 0, 0, "R11 H held under X");
        check_eq("R11 literal", last_pend, 0);
        step('0, '1, 0, 1, "R11 reti X");
        step(9'b000000100, 9'b000000000, 0, 0, "R11 all clear");
        check_eq("R11 clear literal", last_pend, 1);

        // Random phase: R4 R5 R6 R7 R8 R9 R10 R11 R12
        lf = 16'hACE1;
        for (int k = 0; k < 2000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[8:0] & {lf[15:9], lf[1:0]}, {lf[3:0], lf[15:11]},
                 lf[4], lf[5] & lf[6], "R4-mix random");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule